// File: doc/BRIEF.md
# Password-Gated Memory Access Lock

This block decides whether debug and programming commands arriving from outside may touch on-chip memory. It owns a small synchronous word array that stands in for program memory, and a sixteen-word password kept in that array at word addresses 0x10 to 0x1F. After reset, and again after anything that changes the password words, it reads those sixteen words one per cycle. A password made only of 0x0000 words, or only of 0xFFFF words, counts as no password. A lock flag starts set. While it is set and a real password exists, memory commands are answered as refused. A caller removes the refusal by streaming the right sixteen-word key.

The key enters on a valid/ready stream. The word that carries the start mark begins an attempt. All sixteen words are always consumed and compared, so the verdict comes at the same time whether the first word or the last word is wrong. A correct key sets a sticky unlocked state. A mass-erase request fills the whole array with ones in a single cycle, drops any attempt in progress and starts a new scan.

Commands use a second valid/ready stream, and each accepted command gets a one-cycle response. Back-pressure works as follows. `key_ready` is low while a scan runs and in any cycle with `erase_req` high. `cmd_ready` is low in those cycles too, and also whenever `key_valid` is high, so key words take precedence. The response side has no ready input: the caller must take `rsp_*` in the cycle it is valid.

Top module: `pwg_top`

## Requirements
- R1: After reset the lock flag is set. With a defined password stored, `access_granted` stays 0 once the scan ends. Writing 1 to the lock flag through `lock_wr`/`lock_val` also removes access.
- R2: `access_granted` is 0 for the first 16 rising edges after reset is released. After the 17th edge it follows the gate rule: granted when the lock is clear, or the password is blank, or a correct key has been given.
- R3: If all sixteen password words are 0x0000, or all are 0xFFFF, access is granted with no key even while the lock flag is set.
- R4: Clearing the lock flag (`lock_wr`=1, `lock_val`=0) grants access from the next cycle, with no key given.
- R5: A key word accepted with `key_first`=1 is word 0, and the following words are words 1 to 15 in address order. When all sixteen words match, `attempt_done` and `attempt_ok` pulse together for one cycle, one edge after the 16th word is accepted. From then on access is granted.
- R6: If any word of an attempt differs, the attempt fails. `attempt_done` pulses with `attempt_ok`=0, one edge after the 16th word, whatever the position of the wrong word. The gate then stays closed.
- R7: A word accepted with `key_first`=1 clears the unlocked state at that edge and restarts the count at word 0, even in the middle of an attempt.
- R8: A command accepted while access is not granted gets `rsp_denied`=1 and `rsp_data`=0. A refused write leaves memory unchanged.
- R9: A granted read returns the stored word on `rsp_data`. A granted write stores `cmd_wdata`. A granted write to 0x10..0x1F starts a new 17-edge scan, during which access is 0.
- R10: `erase_req` sets every word to 0xFFFF, abandons any attempt (no `attempt_done`) and starts a new scan.
- R11: Key words that arrive with `key_first`=0 while no attempt is open are accepted and ignored. `key_ready` and `cmd_ready` follow the back-pressure rules above.
- R12: `rsp_valid` is high exactly in the cycle after each accepted command, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_wr | input | 1 | Load the lock flag from `lock_val` |
| lock_val | input | 1 | New lock flag value |
| key_valid | input | 1 | Key word present |
| key_ready | output | 1 | Key word accepted this cycle when valid |
| key_first | input | 1 | Marks word 0 of a new attempt |
| key_data | input | 16 | Key word |
| cmd_valid | input | 1 | Memory command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response for the command accepted in the cycle before |
| rsp_denied | output | 1 | Command was refused |
| rsp_data | output | 16 | Read data, 0 for writes and refusals |
| erase_req | input | 1 | Mass-erase request |
| access_granted | output | 1 | Memory commands are allowed |
| attempt_done | output | 1 | One-cycle pulse when a key attempt ends |
| attempt_ok | output | 1 | With `attempt_done`: the key matched |

## Verification
The bench goes after the compare pipeline edges. A mismatch on word 0 and a mismatch on word 15 must both give their verdict on the same edge. A design that stops early would pulse `attempt_done` sooner, and one that checks only part of the key would unlock. A start word in the middle of an attempt, and stray words before any start, are both tested. A design that miscounts either would accept a key that is out of position. A refused write followed by a read after unlocking, an all-zero password under a set lock, and an erase in the middle of an attempt (after which the rest of the words must not produce a verdict) are the other cases. A slip in any of these shows up as a wrong grant or as stale memory.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  // Which requester drives the shared read address this cycle.
  typedef enum logic [1:0] {
    PORT_CMD  = 2'd0,
    PORT_SCAN = 2'd1,
    PORT_KEY  = 2'd2
  } pwg_port_e;

endpackage

// File: rtl/pwg_mem.sv
module pwg_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_q
);

  // Contents survive reset; the array powers up in the erased state.
  logic [DW-1:0] arr [DEPTH] = '{default: '1};

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '1;
    end else if (we) begin
      arr[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= arr[raddr];
  end

endmodule

// File: rtl/pwg_scan.sv
module pwg_scan #(
  parameter int DW       = 16,
  parameter int PW_WORDS = 16,
  localparam int IW      = $clog2(PW_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [DW-1:0] rd_q,
  output logic          issue,
  output logic [IW-1:0] idx,
  output logic          done,
  output logic          blank
);

  localparam logic [IW:0] LAST = (IW+1)'(PW_WORDS);

  logic [IW:0] cnt;
  logic        pend;
  logic        all_zero, all_one;

  assign issue = !done && (cnt != LAST);
  assign idx   = cnt[IW-1:0];
  assign blank = all_zero || all_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pend     <= 1'b0;
      done     <= 1'b0;
      all_zero <= 1'b1;
      all_one  <= 1'b1;
    end else if (restart) begin
      cnt      <= '0;
      pend     <= 1'b0;
      done     <= 1'b0;
      all_zero <= 1'b1;
      all_one  <= 1'b1;
    end else begin
      pend <= issue;
      if (issue) cnt <= cnt + 1'b1;
      if (pend) begin
        all_zero <= all_zero && (rd_q == '0);
        all_one  <= all_one  && (rd_q == '1);
        if (cnt == LAST) done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwg_keycmp.sv
module pwg_keycmp #(
  parameter int DW       = 16,
  parameter int PW_WORDS = 16,
  localparam int IW      = $clog2(PW_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          acc,
  input  logic          first,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] rd_q,
  output logic          rd_req,
  output logic [IW-1:0] rd_idx,
  output logic          unlocked,
  output logic          done,
  output logic          ok
);

  logic          active;
  logic [IW-1:0] idx;
  logic [IW-1:0] cur;
  logic          take, last;
  logic          cmp_v, cmp_first, cmp_last;
  logic [DW-1:0] key_q;
  logic          fail_acc, fail_now;

  // A start word always opens an attempt; other words count only inside one.
  assign take   = acc && (first || active);
  assign cur    = first ? '0 : idx;
  assign last   = (cur == IW'(PW_WORDS - 1));
  assign rd_req = take;
  assign rd_idx = cur;

  // Mismatch is folded in, never short-cut: every word is compared.
  assign fail_now = (cmp_first ? 1'b0 : fail_acc) | (key_q != rd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      cmp_v     <= 1'b0;
      cmp_first <= 1'b0;
      cmp_last  <= 1'b0;
      key_q     <= '0;
      fail_acc  <= 1'b0;
      unlocked  <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
      cmp_v  <= 1'b0;
      done   <= 1'b0;
      ok     <= 1'b0;
    end else begin
      done      <= 1'b0;
      ok        <= 1'b0;
      cmp_v     <= take;
      cmp_first <= first;
      cmp_last  <= last;
      key_q     <= data;
      if (cmp_v) begin
        fail_acc <= fail_now;
        if (cmp_last) begin
          done     <= 1'b1;
          ok       <= !fail_now;
          unlocked <= !fail_now;
        end
      end
      // A new start word wins over a verdict landing on the same edge.
      if (take) begin
        active <= !last;
        idx    <= cur + 1'b1;
        if (first) unlocked <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwg_top.sv
module pwg_top #(
  parameter int DW       = 16,
  parameter int DEPTH    = 64,
  parameter int PW_BASE  = 16,
  parameter int PW_WORDS = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int IW      = $clog2(PW_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_wr,
  input  logic          lock_val,
  input  logic          key_valid,
  output logic          key_ready,
  input  logic          key_first,
  input  logic [DW-1:0] key_data,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic          rsp_denied,
  output logic [DW-1:0] rsp_data,
  input  logic          erase_req,
  output logic          access_granted,
  output logic          attempt_done,
  output logic          attempt_ok
);
  import pwg_pkg::*;

  logic          lock_q;
  logic          scan_issue, scan_done, pw_blank;
  logic [IW-1:0] scan_idx, key_idx;
  logic          key_rd, unlocked;
  logic          key_acc, cmd_acc, cmd_wr_ok, in_pw, restart;
  logic          rsp_rd;
  logic [DW-1:0] rd_q;
  logic [AW-1:0] raddr;
  pwg_port_e     owner;

  assign access_granted = scan_done && (!lock_q || pw_blank || unlocked);
  assign key_ready      = scan_done && !erase_req;
  assign cmd_ready      = key_ready && !key_valid;
  assign key_acc        = key_valid && key_ready;
  assign cmd_acc        = cmd_valid && cmd_ready;
  assign cmd_wr_ok      = cmd_acc && cmd_write && access_granted;
  assign in_pw          = (int'(cmd_addr) >= PW_BASE) && (int'(cmd_addr) < PW_BASE + PW_WORDS);
  assign restart        = erase_req || (cmd_wr_ok && in_pw);

  always_comb begin
    if (scan_issue)  owner = PORT_SCAN;
    else if (key_rd) owner = PORT_KEY;
    else             owner = PORT_CMD;
  end

  always_comb begin
    unique case (owner)
      PORT_SCAN: raddr = AW'(PW_BASE) + AW'(scan_idx);
      PORT_KEY:  raddr = AW'(PW_BASE) + AW'(key_idx);
      default:   raddr = cmd_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_denied <= 1'b0;
      rsp_rd     <= 1'b0;
    end else begin
      if (lock_wr) lock_q <= lock_val;
      rsp_valid  <= cmd_acc;
      rsp_denied <= cmd_acc && !access_granted;
      rsp_rd     <= cmd_acc && access_granted && !cmd_write;
    end
  end

  assign rsp_data = rsp_rd ? rd_q : '0;

  pwg_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .erase (erase_req),
    .we    (cmd_wr_ok),
    .waddr (cmd_addr),
    .wdata (cmd_wdata),
    .raddr (raddr),
    .rd_q  (rd_q)
  );

  pwg_scan #(.DW(DW), .PW_WORDS(PW_WORDS)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .rd_q    (rd_q),
    .issue   (scan_issue),
    .idx     (scan_idx),
    .done    (scan_done),
    .blank   (pw_blank)
  );

  pwg_keycmp #(.DW(DW), .PW_WORDS(PW_WORDS)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (erase_req),
    .acc      (key_acc),
    .first    (key_first),
    .data     (key_data),
    .rd_q     (rd_q),
    .rd_req   (key_rd),
    .rd_idx   (key_idx),
    .unlocked (unlocked),
    .done     (attempt_done),
    .ok       (attempt_ok)
  );

endmodule

// File: rtl/pwg_chk.sv
module pwg_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          key_valid,
  input logic          key_ready,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          rsp_denied,
  input logic [DW-1:0] rsp_data,
  input logic          erase_req,
  input logic          access_granted,
  input logic          attempt_done,
  input logic          attempt_ok
);

  // R12: a response follows every accepted command
  p_rsp_after_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);

  // R12: no response without a command
  p_no_stray_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !rsp_valid);

  // R8: refused commands return no data
  p_denied_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_denied) |-> (rsp_data == '0));

  // R11: erase blocks both streams
  p_erase_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (!key_ready && !cmd_ready));

  // R10: erase closes the gate while the new scan runs
  p_erase_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !access_granted);

  // R6: a verdict lasts one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_done |=> !attempt_done);

  // R5: a pass flag only comes with a verdict
  p_ok_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_ok |-> attempt_done);

  // R5: a pass opens the gate when no scan is running
  p_pass_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_done && attempt_ok && key_ready) |-> access_granted);

  // R2: no grant while the scan is still running
  p_grant_after_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    access_granted |-> (key_ready || erase_req));

  // R11: a command never takes the port while a key word is offered
  p_key_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |-> !(cmd_valid && cmd_ready));

endmodule

bind pwg_top pwg_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_pwg_top.sv
`timescale 1ns/1ps
module test_pwg_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lock_wr, lock_val;
  logic        key_valid, key_ready, key_first;
  logic [15:0] key_data;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [5:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic        rsp_valid, rsp_denied;
  logic [15:0] rsp_data;
  logic        erase_req;
  logic        access_granted, attempt_done, attempt_ok;

  always #2 clk = ~clk;

  pwg_top i_pwg_top (.*);

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string cur_req = "R2";

  // ---------------- behavioural reference ----------------
  int   m_mem [64];
  bit   m_lock, m_unl, m_act, m_fail, m_pend, m_pend_ok;
  bit   m_done, m_ok, m_rv, m_rden;
  int   m_pos, m_scan, m_rdata;

  function automatic bit m_blank();
    bit z = 1'b1;
    bit o = 1'b1;
    for (int i = 16; i < 32; i++) begin
      if (m_mem[i] != 0)      z = 1'b0;
      if (m_mem[i] != 'hFFFF) o = 1'b0;
    end
    return z || o;
  endfunction

  function automatic bit m_grant();
    return (m_scan == 0) && (!m_lock || m_blank() || m_unl);
  endfunction

  always @(posedge clk) begin
    bit g, kr;
    if (!rst_n) begin
      m_lock = 1; m_unl = 0; m_act = 0; m_pend = 0; m_fail = 0; m_pos = 0;
      m_scan = 17; m_done = 0; m_ok = 0; m_rv = 0; m_rden = 0; m_rdata = 0;
    end else begin
      g  = m_grant();
      kr = (m_scan == 0) && !erase_req;
      m_done = 0; m_ok = 0; m_rv = 0; m_rden = 0; m_rdata = 0;
      if (m_scan > 0) m_scan--;
      if (erase_req) begin
        for (int i = 0; i < 64; i++) m_mem[i] = 'hFFFF;
        m_scan = 17; m_act = 0; m_pend = 0;
      end else begin
        if (m_pend) begin
          m_done = 1; m_ok = m_pend_ok; m_unl = m_pend_ok; m_pend = 0;
        end
        if (key_valid && kr) begin
          if (key_first) begin m_act = 1; m_pos = 0; m_fail = 0; m_unl = 0; end
          if (m_act) begin
            if (int'(key_data) != m_mem[16 + m_pos]) m_fail = 1;
            if (m_pos == 15) begin m_pend = 1; m_pend_ok = !m_fail; m_act = 0; end
            else m_pos++;
          end
        end
        if (cmd_valid && kr && !key_valid) begin
          m_rv = 1;
          if (!g) m_rden = 1;
          else if (cmd_write) begin
            m_mem[cmd_addr] = int'(cmd_wdata);
            if (cmd_addr >= 16 && cmd_addr < 32) m_scan = 17;
          end else m_rdata = m_mem[cmd_addr];
        end
      end
      if (lock_wr) m_lock = lock_val;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the clock edge.
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      chk(cur_req, "access_granted", access_granted, m_grant());
      chk(cur_req, "key_ready", key_ready, (m_scan == 0) && !erase_req);
      chk(cur_req, "cmd_ready", cmd_ready, (m_scan == 0) && !erase_req && !key_valid);
      chk(cur_req, "rsp_valid", rsp_valid, m_rv);
      chk(cur_req, "rsp_denied", rsp_denied, m_rden);
      chk(cur_req, "rsp_data", rsp_data, m_rdata);
      chk(cur_req, "attempt_done", attempt_done, m_done);
      chk(cur_req, "attempt_ok", attempt_ok, m_ok);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  function automatic logic [15:0] pw(input int i);
    return 16'hA5C0 ^ 16'(i * 16'h0111);
  endfunction

  task automatic cmd_op(input bit wr, input int addr, input logic [15:0] wd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = 6'(addr); cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic key_word(input logic [15:0] d, input bit f);
    @(negedge clk);
    while (!key_ready) @(negedge clk);
    key_valid = 1; key_data = d; key_first = f;
    @(negedge clk);
    key_valid = 0; key_first = 0;
  endtask

  task automatic send_key(input int bad);
    for (int i = 0; i < 16; i++)
      key_word(pw(i) ^ ((i == bad) ? 16'h0040 : 16'h0000), i == 0);
  endtask

  task automatic lock_op(input bit v);
    @(negedge clk);
    lock_wr = 1; lock_val = v;
    @(negedge clk);
    lock_wr = 0;
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!key_ready) @(negedge clk);
  endtask

  task automatic verdict(input string req, input bit exp_ok);
    #1 chk(req, "attempt_done early", attempt_done, 0);
    @(negedge clk);
    #1 chk(req, "attempt_done", attempt_done, 1);
    chk(req, "attempt_ok", attempt_ok, exp_ok);
  endtask

  // ---------------- scenario ----------------
  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 'hFFFF;
    rst_n = 0; lock_wr = 0; lock_val = 0; key_valid = 0; key_first = 0; key_data = 0;
    cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cmd_wdata = 0; erase_req = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1", "reset access_granted", access_granted, 0);
    chk("R12", "reset rsp_valid", rsp_valid, 0);
    @(negedge clk);
    rst_n = 1;

    // R2: 16 edges closed, open after the 17th (blank erased password, R3)
    repeat (16) @(negedge clk);
    #1 chk("R2", "granted during scan", access_granted, 0);
    @(negedge clk);
    #1 chk("R3", "granted with all-ones password", access_granted, 1);

    // R4: clear the lock, load a password and a data word
    cur_req = "R4";
    lock_op(0);
    #1 chk("R4", "granted with lock clear", access_granted, 1);
    cur_req = "R9";
    for (int i = 0; i < 16; i++) cmd_op(1, 16 + i, pw(i));
    cmd_op(1, 40, 16'h1234);
    cmd_op(0, 40, 16'h0);
    #1 chk("R9", "read back", rsp_data, 16'h1234);
    chk("R12", "rsp_valid after read", rsp_valid, 1);
    cmd_op(0, 21, 16'h0);
    #1 chk("R9", "password word read", rsp_data, pw(5));

    // R1: setting the lock with a defined password closes the gate
    cur_req = "R1";
    lock_op(1);
    #1 chk("R1", "granted after lock set", access_granted, 0);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    wait_ready();
    #1 chk("R1", "granted after reset with password", access_granted, 0);

    // R8: refused commands
    cur_req = "R8";
    cmd_op(0, 40, 16'h0);
    #1 chk("R8", "rsp_denied read", rsp_denied, 1);
    chk("R8", "rsp_data refused", rsp_data, 0);
    cmd_op(1, 40, 16'hDEAD);
    #1 chk("R8", "rsp_denied write", rsp_denied, 1);

    // R11: stray words without a start are dropped
    cur_req = "R11";
    key_word(pw(0), 0);
    key_word(pw(1), 0);
    #1 chk("R11", "no verdict from stray words", attempt_done, 0);
    @(negedge clk);
    #1 chk("R11", "still no verdict", attempt_done, 0);

    // R6: mismatch at the first and at the last word, same timing
    cur_req = "R6";
    send_key(0);
    verdict("R6", 0);
    send_key(15);
    verdict("R6", 0);
    #1 chk("R6", "gate after failed key", access_granted, 0);

    // R5: correct key opens the gate; refused write did not land (R8)
    cur_req = "R5";
    send_key(-1);
    verdict("R5", 1);
    #1 chk("R5", "granted after good key", access_granted, 1);
    cmd_op(0, 40, 16'h0);
    #1 chk("R8", "refused write left data", rsp_data, 16'h1234);

    // R7: a start word clears the unlocked state; restart mid-attempt
    cur_req = "R7";
    key_word(16'h0BAD, 1);
    #1 chk("R7", "granted after new start", access_granted, 0);
    key_word(pw(1), 0);
    send_key(-1);
    verdict("R7", 1);
    #1 chk("R7", "granted after restarted key", access_granted, 1);

    // R9: a write to the password area rescans
    cur_req = "R9";
    cmd_op(1, 31, pw(15));
    #1 chk("R9", "granted during rescan", access_granted, 0);
    wait_ready();
    #1 chk("R9", "granted after rescan", access_granted, 1);

    // R3: an all-zero password under a set lock still grants
    cur_req = "R3";
    lock_op(0);
    for (int i = 0; i < 16; i++) cmd_op(1, 16 + i, 16'h0000);
    lock_op(1);
    wait_ready();
    key_word(16'h5555, 1);
    #1 chk("R3", "granted with zero password", access_granted, 1);

    // R10: erase in the middle of an attempt
    cur_req = "R10";
    @(negedge clk); erase_req = 1;
    @(negedge clk); erase_req = 0;
    #1 chk("R10", "granted right after erase", access_granted, 0);
    for (int i = 1; i < 16; i++) key_word(16'h5555, 0);
    #1 chk("R10", "no verdict after erase", attempt_done, 0);
    @(negedge clk);
    #1 chk("R10", "still no verdict", attempt_done, 0);
    chk("R10", "granted after erase", access_granted, 1);
    cmd_op(0, 24, 16'h0);
    #1 chk("R10", "erased password word", rsp_data, 16'hFFFF);
    cmd_op(0, 40, 16'h0);
    #1 chk("R10", "erased data word", rsp_data, 16'hFFFF);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule